// File: doc/BRIEF.md
# Local-Bus Graphics Chip-Select Decoder

This block sits between a 32-bit local bus and a graphics controller and turns each bus cycle into at most one of two active-low chip selects. The frame select covers the legacy video memory window, the linear framebuffer aperture and low I/O ports. The register select covers a memory-mapped register window. The aperture base comes from a board jumper code. An optional mode forces the 32 MB address bit on.

The register window sits at a fixed offset of 16 MB above the aperture base. Everything from 32 MB above the base upward is reserved and selects nothing. The block samples the bus when the address strobe is seen. It holds the resulting select until the cycle-end indication arrives. It also presents the chosen base in 64 KB units as a high byte and a low byte, so that a base register can be read back by software.

Top module: `gfx_addr_decoder`

## Requirements
- R1: A memory cycle (`memIoN`=1) whose address lies in 0x000A0000..0x000BFFFF asserts `fbSelN`. The addresses 0x0009FFFF and 0x000C0000 assert no select.
- R2: A memory cycle at base..base+0x3FFFFF asserts `fbSelN`. The addresses base+0x400000 and base-1 assert no select.
- R3: A memory cycle at base+0x1000000..base+0x100FFFF asserts `regSelN` only. The address base+0x1010000 asserts no select.
- R4: A memory cycle at base+0x2000000 or above it, inside the decoded range, asserts no select.
- R5: With `altBaseMode`=0, the 3-bit `jumperCode` values 0,1,2,3,4 give bases of 32, 64, 128, 256 and 512 MB. Values 5..7 give 64 MB.
- R6: With `altBaseMode`=1, the base is the R5 base ORed with 32 MB. This gives 32, 96, 160, 288 and 544 MB, and 96 MB for codes 5..7.
- R7: An I/O cycle (`memIoN`=0) with an address below 0x10000 asserts `fbSelN`. An I/O cycle at 0x10000 or above asserts no select, even when the address falls in the aperture.
- R8: `{baseHi, baseLo}` equals base >> 16. For example, 544 MB reads as 0x22, 0x00.
- R9: On a clock edge in the idle state with `addrStrobeN`=0, the decoder captures the selects. They become visible after that edge and stay stable while the address and strobe change. They are released after the edge that samples `cycleEndN`=0. A strobe seen during an open cycle is ignored.
- R10: After reset both selects are high, and the two selects are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 32 | Bus byte address |
| memIoN | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addrStrobeN | input | 1 | Active-low address strobe |
| cycleEndN | input | 1 | Active-low end-of-cycle indication |
| jumperCode | input | 3 | Aperture base selection code |
| altBaseMode | input | 1 | Forces the 32 MB base bit on |
| fbSelN | output | 1 | Active-low legacy/framebuffer/I-O select |
| regSelN | output | 1 | Active-low register window select |
| baseHi | output | 8 | Base in 64 KB units, upper byte |
| baseLo | output | 8 | Base in 64 KB units, lower byte |

## Verification
The bench uses the default parameters: a 32-bit address, five bases starting at 32 MB, a 4 MB aperture and a 64 KB register window at +16 MB. With these values every jumper code in both base modes can be swept. This includes the 544 MB alternate base, whose reserved region above +32 MB still fits inside the address space. So every aperture, register and reserved edge is probed for every base the jumper can produce. The bench also probes the legacy window edges, I/O port edges, and a second strobe raised during an open cycle.

// File: rtl/gfx_dec_pkg.sv
package gfx_dec_pkg;
  typedef struct packed {
    logic capture;
    logic dropSel;
  } ctrlStrobes_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} busState_e;
endpackage

// File: rtl/gfx_dec_ctrl.sv
module gfx_dec_ctrl
  import gfx_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrStrobeN,
  input  logic         cycleEndN,
  output ctrlStrobes_t strobes
);
  busState_e state, stateNext;

  always_comb begin
    strobes.capture = (state == ST_IDLE) && !addrStrobeN;
    strobes.dropSel = (state == ST_BUSY) && !cycleEndN;
    stateNext = state;
    if (strobes.capture) stateNext = ST_BUSY;
    else if (strobes.dropSel) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R9: an open cycle only closes on a sampled cycle end
  p_busy_until_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && cycleEndN) |=> (state == ST_BUSY));
endmodule

// File: rtl/gfx_dec_path.sv
module gfx_dec_path
  import gfx_dec_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_BASES     = 5,
  parameter int MIN_BASE_LOG2 = 25,
  parameter int DEFAULT_IDX   = 1,
  parameter int FB_LOG2       = 22,
  parameter int REG_OFS_LOG2  = 24,
  parameter int REG_WIN_LOG2  = 16,
  parameter int IO_WIN_LOG2   = 16,
  parameter int UNIT_LOG2     = 16,
  parameter int READ_W        = 8,
  parameter int JMP_W         = $clog2(NUM_BASES),
  parameter logic [ADDR_W-1:0] LEGACY_LO = 'h000A_0000,
  parameter logic [ADDR_W-1:0] LEGACY_HI = 'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              memIoN,
  input  logic [JMP_W-1:0]  jumperCode,
  input  logic              altBaseMode,
  output logic              fbSelN,
  output logic              regSelN,
  output logic [READ_W-1:0] baseHi,
  output logic [READ_W-1:0] baseLo
);
  localparam int UNIT_W  = 2 * READ_W;
  localparam int REG_TW  = ADDR_W - REG_WIN_LOG2;
  localparam logic [REG_TW-1:0] REG_TAG = REG_TW'(1) << (REG_OFS_LOG2 - REG_WIN_LOG2);

  logic [ADDR_W-1:0] baseTable [NUM_BASES];
  logic [ADDR_W-1:0] rawBase, base;
  logic [ADDR_W:0]   diff;
  logic [ADDR_W-1:0] offs;
  logic              below, inFb, inReg, inLegacy, inIo, fbHit, regHit;

  generate
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
      assign baseTable[g] = ADDR_W'(1) << (MIN_BASE_LOG2 + g);
    end
  endgenerate

  always_comb begin
    if ({1'b0, jumperCode} < (JMP_W + 1)'(NUM_BASES)) rawBase = baseTable[jumperCode];
    else                                                rawBase = baseTable[DEFAULT_IDX];
    base = altBaseMode ? (rawBase | baseTable[0]) : rawBase;
  end

  assign {baseHi, baseLo} = base[UNIT_LOG2 +: UNIT_W];

  always_comb begin
    diff     = {1'b0, busAddr} - {1'b0, base};
    below    = diff[ADDR_W];
    offs     = diff[ADDR_W-1:0];
    inFb     = !below && (offs[ADDR_W-1:FB_LOG2] == '0);
    inReg    = !below && (offs[ADDR_W-1:REG_WIN_LOG2] == REG_TAG);
    inLegacy = (busAddr >= LEGACY_LO) && (busAddr <= LEGACY_HI);
    inIo     = (busAddr[ADDR_W-1:IO_WIN_LOG2] == '0);
    fbHit    = memIoN ? (inLegacy || inFb) : inIo;
    regHit   = memIoN && inReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbSelN  <= 1'b1;
      regSelN <= 1'b1;
    end else if (strobes.capture) begin
      fbSelN  <= !fbHit;
      regSelN <= !regHit;
    end else if (strobes.dropSel) begin
      fbSelN  <= 1'b1;
      regSelN <= 1'b1;
    end
  end

  p_sel_mutex_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!fbSelN && !regSelN));
  p_base_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    !altBaseMode |-> $onehot({baseHi, baseLo}));
  p_alt_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    altBaseMode |-> base[MIN_BASE_LOG2]);
endmodule

// File: rtl/gfx_addr_decoder.sv
module gfx_addr_decoder
  import gfx_dec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BASES = 5,
  parameter int READ_W    = 8,
  parameter int JMP_W     = $clog2(NUM_BASES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              memIoN,
  input  logic              addrStrobeN,
  input  logic              cycleEndN,
  input  logic [JMP_W-1:0]  jumperCode,
  input  logic              altBaseMode,
  output logic              fbSelN,
  output logic              regSelN,
  output logic [READ_W-1:0] baseHi,
  output logic [READ_W-1:0] baseLo
);
  ctrlStrobes_t strobes;

  gfx_dec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN),
    .cycleEndN(cycleEndN), .strobes(strobes)
  );

  gfx_dec_path #(.ADDR_W(ADDR_W), .NUM_BASES(NUM_BASES), .READ_W(READ_W), .JMP_W(JMP_W)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr), .memIoN(memIoN),
    .jumperCode(jumperCode), .altBaseMode(altBaseMode),
    .fbSelN(fbSelN), .regSelN(regSelN), .baseHi(baseHi), .baseLo(baseLo)
  );

  // R9: a select held with no cycle end stays unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((!fbSelN || !regSelN) && cycleEndN) |=> $stable({fbSelN, regSelN}));
  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((!fbSelN || !regSelN) && !cycleEndN) |=> (fbSelN && regSelN));
  p_fb_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fbSelN) |-> $past(!addrStrobeN));
  p_reg_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regSelN) |-> $past(!addrStrobeN));
endmodule

// File: tb/gfx_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module gfx_addr_decoder_tb_top;
  localparam time CLK_T = 8ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic memIoN = 1'b1, addrStrobeN = 1'b1, cycleEndN = 1'b1, altBaseMode = 1'b0;
  logic [2:0] jumperCode = '0;
  logic fbSelN, regSelN;
  logic [7:0] baseHi, baseLo;
  int checks = 0, errors = 0;

  always #(CLK_T/2) clk = ~clk;

  gfx_addr_decoder dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .memIoN(memIoN), .addrStrobeN(addrStrobeN),
    .cycleEndN(cycleEndN), .jumperCode(jumperCode), .altBaseMode(altBaseMode),
    .fbSelN(fbSelN), .regSelN(regSelN), .baseHi(baseHi), .baseLo(baseLo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Base from R5 and R6
  function automatic logic [31:0] refBase(input logic [2:0] code, input logic alt);
    int idx = (code < 5) ? int'(code) : 1;
    logic [31:0] b = 32'h1 << (25 + idx);
    if (alt) b = b | 32'h0200_0000;
    return b;
  endfunction

  // Expected selects from R1..R4 and R7
  function automatic logic [1:0] refSel(input logic [31:0] a, input logic mio, input logic [31:0] b);
    logic fb = 1'b0, rg = 1'b0;
    if (!mio) fb = (a < 32'h10000);
    else begin
      if (a >= 32'hA0000 && a <= 32'hBFFFF) fb = 1'b1;
      if (a >= b && a - b < 32'h0040_0000) fb = 1'b1;
      if (a >= b + 32'h0100_0000 && a < b + 32'h0101_0000) rg = 1'b1;
    end
    return {~fb, ~rg};
  endfunction

  task automatic busCycle(input logic [31:0] a, input logic mio, input string req);
    logic [1:0] e = refSel(a, mio, refBase(jumperCode, altBaseMode));
    @(negedge clk); busAddr = a; memIoN = mio; addrStrobeN = 1'b0;
    @(negedge clk); addrStrobeN = 1'b1; busAddr = 32'hFFFF_FFFF; memIoN = ~mio;
    chk({fbSelN, regSelN} == e, req, {30'd0, fbSelN, regSelN}, {30'd0, e});
    @(negedge clk);
    chk({fbSelN, regSelN} == e, {req, " hold R9"}, {30'd0, fbSelN, regSelN}, {30'd0, e});
    cycleEndN = 1'b0;
    @(negedge clk); cycleEndN = 1'b1;
    chk({fbSelN, regSelN} == 2'b11, "release R9", {30'd0, fbSelN, regSelN}, 32'd3);
  endtask

  task automatic testReset();
    chk(fbSelN && regSelN, "reset R10", {30'd0, fbSelN, regSelN}, 32'd3);
  endtask

  task automatic testLegacy();
    jumperCode = 3'd1; altBaseMode = 1'b0;
    busCycle(32'h000A_0000, 1'b1, "legacy low R1");
    busCycle(32'h000B_FFFF, 1'b1, "legacy high R1");
    busCycle(32'h0009_FFFF, 1'b1, "below legacy R1");
    busCycle(32'h000C_0000, 1'b1, "above legacy R1");
  endtask

  task automatic testIo();
    jumperCode = 3'd0; altBaseMode = 1'b0;
    busCycle(32'h0000_03D4, 1'b0, "io low R7");
    busCycle(32'h0000_FFFF, 1'b0, "io top R7");
    busCycle(32'h0001_0000, 1'b0, "io above R7");
    busCycle(32'h0200_0000, 1'b0, "io at aperture R7");
  endtask

  task automatic testSweep();
    for (int alt = 0; alt < 2; alt++) begin
      for (int code = 0; code < 8; code++) begin
        logic [31:0] b;
        @(negedge clk); jumperCode = 3'(code); altBaseMode = alt[0];
        b = refBase(3'(code), alt[0]);
        #1;
        chk({baseHi, baseLo} == b[31:16], alt ? "readback R6 R8" : "readback R5 R8",
            {16'd0, baseHi, baseLo}, {16'd0, b[31:16]});
        busCycle(b,                 1'b1, "fb start R2");
        busCycle(b + 32'h003F_FFFF, 1'b1, "fb end R2");
        busCycle(b + 32'h0040_0000, 1'b1, "fb past R2");
        busCycle(b - 32'h1,         1'b1, "below base R2");
        busCycle(b + 32'h0100_0000, 1'b1, "reg start R3");
        busCycle(b + 32'h0100_FFFF, 1'b1, "reg end R3");
        busCycle(b + 32'h0101_0000, 1'b1, "reg past R3");
        busCycle(b + 32'h0200_0000, 1'b1, "reserved R4");
        busCycle(b + 32'h0300_0000, 1'b1, "reserved high R4");
      end
    end
  endtask

  task automatic testStrobeIgnored();
    logic [31:0] b;
    jumperCode = 3'd2; altBaseMode = 1'b0; b = refBase(3'd2, 1'b0);
    @(negedge clk); busAddr = 32'h000A_8000; memIoN = 1'b1; addrStrobeN = 1'b0;
    @(negedge clk);
    chk(!fbSelN && regSelN, "capture R9", {30'd0, fbSelN, regSelN}, 32'd1);
    busAddr = b + 32'h0100_0000;
    @(negedge clk); addrStrobeN = 1'b1;
    chk(!fbSelN && regSelN, "second strobe ignored R9", {30'd0, fbSelN, regSelN}, 32'd1);
    cycleEndN = 1'b0;
    @(negedge clk); cycleEndN = 1'b1;
    chk(fbSelN && regSelN, "release after end R9", {30'd0, fbSelN, regSelN}, 32'd3);
    @(negedge clk);
    chk(fbSelN && regSelN, "idle without strobe R9", {30'd0, fbSelN, regSelN}, 32'd3);
  endtask

  initial begin
    #(CLK_T * 200000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLegacy();
    testIo();
    testSweep();
    testStrobeIgnored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule